// File: doc/BRIEF.md
# Reset and Boot Release Sequencer

This block produces a processor's internal reset. It takes two reset sources: an active-low reset pin from the board, and a supply-good flag that drops at power-up and whenever the supply sags below its threshold. Each source passes through its own clock synchronizer. After both sources go quiet, the core is held in reset for a programmable lock interval so that the clock multiplier can settle. Any new reset activity during that wait starts the interval over.

When the interval ends, the sequencer pulses a strobe that empties the stack pointers. Interrupts stay forced masked the whole time. The sequencer then waits until no external bus request is pending. Only then does it release the core in the same cycle that it loads the program counter with a fixed boot vector and flags the start of booting.

Every output is a flop. The synchronized reset request acts as a synchronous active-high reset on all state.

Top module: `boot_seq`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst` is 1 no later than SYNC_STAGES+1 cycles after the fall, from any state. The outputs then rest at `core_rst`=1, `irq_mask_force`=1, `sp_clear`=0, `pc_load`=0, `boot_start`=0 and `pc_addr`=0.
- R2: A low on `supply_ok` has the same effect as R1, including while the core is running (brown-out).
- R3: After both sources become inactive, `core_rst` stays 1 for at least SYNC_STAGES+LOCK_CYCLES+2 cycles (LOCK_CYCLES defaults to 512). With no bus request, it falls exactly that many cycles after the release.
- R4: Any reassertion of either source, even for one cycle, restarts the whole sequence. The release then comes SYNC_STAGES+LOCK_CYCLES+2 cycles after the source goes inactive again.
- R5: `sp_clear` is a one-cycle pulse with `core_rst` high. It comes SYNC_STAGES+LOCK_CYCLES cycles after the sources go inactive.
- R6: While `bus_req` is 1 after initialization, the sequencer holds with `core_rst`=1 and `pc_load`=0. It releases in the cycle after the first clock edge that samples `bus_req`=0.
- R7: `pc_load` and `boot_start` are the same one-cycle pulse, in the first cycle with `core_rst`=0. During it, `pc_addr` equals BOOT_ADDR (default 24'hFF0000); otherwise `pc_addr` is 0.
- R8: `irq_mask_force` stays 1 through the boot cycle and falls in the cycle after it.
- R9: Once running, `bus_req` has no effect. The outputs stay at `core_rst`=0 with no pulses until a source reasserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| ext_rst_n | input | 1 | Board reset pin, active low, asynchronous |
| supply_ok | input | 1 | Supply-good flag, low means power-on or brown-out reset |
| bus_req | input | 1 | External bus request pending, synchronous |
| core_rst | output | 1 | Internal core reset, active high |
| irq_mask_force | output | 1 | Forces all interrupts masked |
| sp_clear | output | 1 | One-cycle strobe that empties the stack pointers |
| pc_load | output | 1 | Loads the program counter from `pc_addr` |
| pc_addr | output | ADDR_W | Boot vector during `pc_load`, else 0 |
| boot_start | output | 1 | One-cycle flag that booting begins |

## Verification
Every cycle, the assertions check the following:
- The boot pulse is never issued after an edge that saw a bus request.
- The boot pulse and the stack strobe are single-cycle.
- The boot pulse coincides with the vector and the release.
- The mask drops right after the boot pulse.
- Release never comes before the lock window has elapsed since the last source activity.

Only the bench's scenarios can show the following:
- The exact release cycle for every restart point across the lock window.
- The double stack strobe when a glitch lands just after initialization.
- The hold for each bus-request length.
- The brown-out reaction time.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_INIT  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_BOOT  = 3'd3,
    ST_RUN   = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic core_rst;
    logic irq_mask;
    logic sp_clear;
    logic boot;
  } seq_out_t;

  function automatic seq_out_t decode_state(seq_state_t s);
    seq_out_t o;
    o.core_rst = (s == ST_HOLD) || (s == ST_INIT) || (s == ST_WAIT);
    o.irq_mask = (s != ST_RUN);
    o.sp_clear = (s == ST_INIT);
    o.boot     = (s == ST_BOOT);
    return o;
  endfunction
endpackage

// File: rtl/boot_seq_sync.sv
module boot_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic act_async,
  output logic act_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    chain_q <= {chain_q[STAGES-2:0], act_async};
  end

  assign act_sync = chain_q[STAGES-1];
endmodule

// File: rtl/boot_seq_lock_cnt.sv
module boot_seq_lock_cnt #(
  parameter int LOCK_CYCLES = 512
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (clr)
      cnt_q <= '0;
    else if (en && !done)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 24'hFF0000
) (
  input  logic              clk,
  input  logic              rst_req,
  input  logic              lock_done,
  input  logic              bus_req,
  output logic              in_hold,
  output logic              core_rst,
  output logic              irq_mask_force,
  output logic              sp_clear,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_addr,
  output logic              boot_start
);
  seq_state_t state_q, state_d;
  seq_out_t   out_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD: if (lock_done) state_d = ST_INIT;
      ST_INIT: state_d = ST_WAIT;
      ST_WAIT: if (!bus_req) state_d = ST_BOOT;
      ST_BOOT: state_d = ST_RUN;
      ST_RUN:  state_d = ST_RUN;
      default: state_d = ST_HOLD;
    endcase
    if (rst_req) state_d = ST_HOLD;
  end

  assign out_d   = decode_state(state_d);
  assign in_hold = (state_q == ST_HOLD);

  always_ff @(posedge clk) begin
    state_q        <= state_d;
    core_rst       <= out_d.core_rst;
    irq_mask_force <= out_d.irq_mask;
    sp_clear       <= out_d.sp_clear;
    pc_load        <= out_d.boot;
    boot_start     <= out_d.boot;
    pc_addr        <= out_d.boot ? BOOT_ADDR : '0;
  end
endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int                ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] BOOT_ADDR   = 24'hFF0000,
  parameter int                LOCK_CYCLES = 512,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              supply_ok,
  input  logic              bus_req,
  output logic              core_rst,
  output logic              irq_mask_force,
  output logic              sp_clear,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_addr,
  output logic              boot_start
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0] src_act;
  logic [N_SRC-1:0] src_sync;
  logic             rst_req;
  logic             lock_done;
  logic             in_hold;

  assign src_act = {~supply_ok, ~ext_rst_n};

  for (genvar i = 0; i < N_SRC; i++) begin : g_sync
    boot_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .act_async(src_act[i]),
      .act_sync (src_sync[i])
    );
  end

  assign rst_req = |src_sync;

  boot_seq_lock_cnt #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk (clk),
    .clr (rst_req),
    .en  (in_hold),
    .done(lock_done)
  );

  boot_seq_fsm #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR)) u_fsm (
    .clk           (clk),
    .rst_req       (rst_req),
    .lock_done     (lock_done),
    .bus_req       (bus_req),
    .in_hold       (in_hold),
    .core_rst      (core_rst),
    .irq_mask_force(irq_mask_force),
    .sp_clear      (sp_clear),
    .pc_load       (pc_load),
    .pc_addr       (pc_addr),
    .boot_start    (boot_start)
  );
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int                ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] BOOT_ADDR   = 24'hFF0000,
  parameter int                LOCK_CYCLES = 512,
  parameter int                SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              ext_rst_n,
  input logic              supply_ok,
  input logic              bus_req,
  input logic              core_rst,
  input logic              irq_mask_force,
  input logic              sp_clear,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_addr,
  input logic              boot_start
);
  localparam int MIN_HOLD = SYNC_STAGES + LOCK_CYCLES + 2;

  logic src_on;
  int   quiet_cnt;

  assign src_on = !ext_rst_n || !supply_ok;

  always_ff @(posedge clk) begin
    if (src_on)
      quiet_cnt <= 0;
    else if (quiet_cnt < MIN_HOLD + 4)
      quiet_cnt <= quiet_cnt + 1;
  end

  // R3: release only after the full lock window of quiet sources
  a_r3_lock_window: assert property (@(posedge clk) disable iff (src_on)
    $fell(core_rst) |-> quiet_cnt >= MIN_HOLD);

  // R5: stack strobe is single-cycle and only under reset
  a_r5_sp_pulse: assert property (@(posedge clk) disable iff (src_on)
    sp_clear |-> core_rst ##1 !sp_clear);

  // R6: no boot after an edge that saw a bus request
  a_r6_bus_gate: assert property (@(posedge clk) disable iff (src_on)
    pc_load |-> $past(!bus_req));

  // R7: boot pulse carries the vector, the flag and the release
  a_r7_boot_pulse: assert property (@(posedge clk) disable iff (src_on)
    pc_load |-> (boot_start && !core_rst && pc_addr == BOOT_ADDR && $past(core_rst)));

  a_r7_single: assert property (@(posedge clk) disable iff (src_on)
    pc_load |=> !pc_load && !boot_start);

  // R8: mask held in the boot cycle, lifted right after
  a_r8_mask_drop: assert property (@(posedge clk) disable iff (src_on)
    pc_load |-> irq_mask_force ##1 !irq_mask_force);
endmodule

bind boot_seq boot_seq_chk #(
  .ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR),
  .LOCK_CYCLES(LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .supply_ok(supply_ok), .bus_req(bus_req),
  .core_rst(core_rst), .irq_mask_force(irq_mask_force), .sp_clear(sp_clear),
  .pc_load(pc_load), .pc_addr(pc_addr), .boot_start(boot_start)
);

// File: tb/boot_seq_tb.sv
module boot_seq_tb;
  localparam int          S  = 2;
  localparam int          L  = 20;
  localparam int          AW = 24;
  localparam logic [AW-1:0] BA = 24'hFF0000;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic bus_req = 1'b0;
  logic core_rst, irq_mask_force, sp_clear, pc_load, boot_start;
  logic [AW-1:0] pc_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  boot_seq #(.ADDR_W(AW), .BOOT_ADDR(BA), .LOCK_CYCLES(L), .SYNC_STAGES(S)) u_dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .supply_ok(supply_ok), .bus_req(bus_req),
    .core_rst(core_rst), .irq_mask_force(irq_mask_force), .sp_clear(sp_clear),
    .pc_load(pc_load), .pc_addr(pc_addr), .boot_start(boot_start)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_up();
    end
  end

  // g: glitch negedge (0 = none), via_sup picks the glitching source,
  // b: negedge at which bus_req drops (0 = never raised)
  task automatic run(input int g, input bit via_sup, input int b);
    int base, t_rel, sp_a, sp_b;
    bit sp_a_ok;
    base  = S + L + 2 + ((g > 0) ? g + 1 : 0);
    t_rel = (b + 1 > base) ? b + 1 : base;
    sp_a  = S + L;
    sp_b  = (g > 0) ? g + 1 + S + L : -1;
    sp_a_ok = (g == 0) || (g + 3 > S + L);
    ext_rst_n = 1'b0;
    bus_req   = (b > 0);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (running)
        chk(core_rst == (k >= S + 1), "R1", "core_rst after pin fall", core_rst, k >= S + 1);
    end
    chk(core_rst && irq_mask_force && !sp_clear && !pc_load && !boot_start && pc_addr == 0,
        "R1", "reset output state",
        {core_rst, irq_mask_force, sp_clear, pc_load, boot_start}, 5'b11000);
    ext_rst_n = 1'b1;
    for (int k = 1; k <= t_rel + 5; k++) begin
      bit sp_exp;
      @(negedge clk);
      sp_exp = (sp_a_ok && k == sp_a) || (k == sp_b);
      chk(core_rst == (k < t_rel), (g > 0) ? "R4" : (b > 0 ? "R6" : "R3"),
          "core_rst", core_rst, k < t_rel);
      chk(sp_clear == sp_exp, "R5", "sp_clear", sp_clear, sp_exp);
      chk(pc_load == (k == t_rel) && boot_start == (k == t_rel), "R7", "pc_load/boot_start",
          {pc_load, boot_start}, (k == t_rel) ? 2'b11 : 2'b00);
      chk(pc_addr == ((k == t_rel) ? BA : '0), "R7", "pc_addr", pc_addr, (k == t_rel) ? BA : 0);
      chk(irq_mask_force == (k <= t_rel), "R8", "irq_mask_force", irq_mask_force, k <= t_rel);
      if (k > t_rel)
        chk(!core_rst && !pc_load && !sp_clear, "R9", "running outputs",
            {core_rst, pc_load, sp_clear}, 3'b000);
      if (g > 0 && k == g) begin
        if (via_sup) supply_ok = 1'b0; else ext_rst_n = 1'b0;
      end
      if (g > 0 && k == g + 1) begin
        supply_ok = 1'b1;
        ext_rst_n = 1'b1;
      end
      if (b > 0 && k == b) bus_req = 1'b0;
      if (k == t_rel + 2) bus_req = 1'b1;
    end
    bus_req = 1'b0;
    running = 1'b1;
  endtask

  task automatic brownout();
    @(negedge clk);
    supply_ok = 1'b0;
    for (int k = 1; k <= S + 2; k++) begin
      @(negedge clk);
      chk(core_rst == (k >= S + 1), "R2", "core_rst after supply drop", core_rst, k >= S + 1);
      chk(irq_mask_force == (k >= S + 1), "R2", "mask after supply drop", irq_mask_force, k >= S + 1);
    end
    supply_ok = 1'b1;
    for (int k = 1; k <= S + L + 4; k++) begin
      @(negedge clk);
      chk(core_rst == (k < S + L + 2), "R2", "release after supply return", core_rst, k < S + L + 2);
    end
  endtask

  initial begin
    run(0, 1'b0, 0);
    for (int g = 1; g <= S + L - 1; g++)
      run(g, g[0], 0);
    run(0, 1'b0, S + L - 3);
    run(0, 1'b0, S + L + 1);
    run(0, 1'b0, S + L + 2);
    run(0, 1'b0, S + L + 5);
    run(0, 1'b0, S + L + 12);
    brownout();
    brownout();
    finish_up();
  end
endmodule